// File: doc/BRIEF.md
# Dual-Channel Transmit Frame Buffer

This block sits between a host register port and a byte-wide transmit stream. It holds two frame buffers, channel 0 and channel 1, each `BUF_BYTES` long. The host picks a channel with a select register and then pushes 32-bit words through a single data register. Each push lands at that channel's running write offset. The host then programs the channel's frame length and writes the channel's start register. The block plays the frame out one byte per handshake on a valid/ready interface, tagged with the channel number and a last-byte flag.

When a send finishes, the block raises that channel's status bit, and the level interrupt follows the status bits masked by the enable register. A request for the second channel while the first is still sending is held and runs next. Out-of-range select and length values are clamped rather than rejected. A self-clearing reset bit in the control register brings all state back to its reset value.

Register word addresses: 0 control (bit 1 transmit enable, bit 0 soft reset), 1 channel select, 2 data, 3 length ch0, 4 length ch1, 5 start ch0, 6 start ch1, 7 interrupt enable, 8 interrupt status. Unlisted addresses read 0.

Top module: `txb_top`

## Requirements
- R1: After reset every readable register returns 0, irq_o is low and tx_valid_o is low.
- R2: A write to channel select (address 1) stores 0 or 1 as written, and stores 0 for any value of 2 or more. The register reads back the stored value.
- R3: Each write to the data register (address 2) stores the word in the selected channel's buffer at that channel's write offset and advances the offset by 4 bytes. Once the offset has reached BUF_BYTES, further data writes are dropped and do not wrap onto word 0.
- R4: A write to a length register (address 3 for ch0, 4 for ch1) larger than BUF_BYTES stores BUF_BYTES, and any other value is stored as written. The register reads back the stored value.
- R5: Writing 1 to bit 0 of a start register (address 5 for ch0, 6 for ch1) begins a send only when control bit 1 is set. Without that bit, no byte appears and no status bit is set.
- R6: A send presents buffer bytes from byte 0 upward, least significant byte of each 32-bit word first, exactly length bytes in total. tx_chan_o carries the channel number and tx_last_o is high on the final byte only. While tx_ready_i is low, the byte and the channel are held.
- R7: When a channel's send completes, status bit N is set for channel N and that channel's write offset returns to 0, so the next data write fills word 0.
- R8: irq_o is high exactly when (status AND enable) is nonzero, with enable at address 7 and status at address 8. A write to status clears the bits written as 1 and leaves the other bits unchanged.
- R9: A control write with bit 0 set clears select, lengths, offsets, enable, status and any send in progress or waiting. The other written control bits are kept, and bit 0 reads back as 0.
- R10: A start for a channel that is already sending or waiting is ignored. A start for the other channel during a send waits and runs after the current frame, so frames leave in request order.
- R11: A send with length 0 completes without presenting any byte and still sets the channel's status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write word address |
| wr_data_i | input | DATA_W | Register write data |
| rd_addr_i | input | ADDR_W | Register read word address |
| rd_data_o | output | DATA_W | Register read data (combinational) |
| tx_data_o | output | 8 | Transmit byte |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_ready_i | input | 1 | Transmit byte accepted |
| tx_last_o | output | 1 | Final byte of frame |
| tx_chan_o | output | 1 | Channel being sent |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest state to reach is the queued request: a start for the second channel has to arrive while the first frame is still draining, and repeat starts on both channels have to land inside that window. The bench issues these writes back to back right after a 40-byte start, while a random ready (low one cycle in four) stretches the frame. It then checks that exactly two frames come out, in order. The buffer-full boundary is reached by writing past 512 words into each buffer before sending a full 2048-byte frame. The soft reset is fired in the middle of a long stalled frame.

// File: rtl/txb_pkg.sv
package txb_pkg;
  localparam int NUM_CH = 2;
  localparam int CH_W   = 1;
  // register word addresses
  localparam int A_CTRL = 0;
  localparam int A_SEL  = 1;
  localparam int A_DATA = 2;
  localparam int A_LEN0 = 3;
  localparam int A_GO0  = 5;
  localparam int A_IEN  = 7;
  localparam int A_ISTS = 8;
  localparam int CTRL_RST_BIT = 0;
  localparam int CTRL_EN_BIT  = 1;
endpackage

// File: rtl/txb_bank.sv
module txb_bank #(
  parameter int DATA_W    = 32,
  parameter int BUF_BYTES = 2048,
  localparam int LANES  = DATA_W / 8,
  localparam int WORDS  = BUF_BYTES / LANES,
  localparam int OFF_W  = $clog2(BUF_BYTES) + 1,
  localparam int WIDX_W = $clog2(WORDS),
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              done_i,
  input  logic [WIDX_W-1:0] rd_idx_i,
  output logic [DATA_W-1:0] rd_word_o
);
  logic [DATA_W-1:0] mem_q [WORDS];
  logic [OFF_W-1:0]  off_q;
  logic              room;

  assign room = off_q < OFF_W'(BUF_BYTES);

  always_ff @(posedge clk_i) begin
    if (wr_i && room) mem_q[off_q[OFF_W-2:LANE_W]] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 off_q <= '0;
    else if (clr_i || done_i)    off_q <= '0;
    else if (wr_i && room)       off_q <= off_q + OFF_W'(LANES);
  end

  assign rd_word_o = mem_q[rd_idx_i];
endmodule

// File: rtl/txb_sched.sv
module txb_sched
  import txb_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BUF_BYTES = 2048,
  localparam int LANES  = DATA_W / 8,
  localparam int WORDS  = BUF_BYTES / LANES,
  localparam int OFF_W  = $clog2(BUF_BYTES) + 1,
  localparam int WIDX_W = $clog2(WORDS),
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           clr_i,
  input  logic                           en_i,
  input  logic [NUM_CH-1:0]              go_i,
  input  logic [NUM_CH-1:0][OFF_W-1:0]   len_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  words_i,
  output logic [WIDX_W-1:0]              rd_idx_o,
  output logic [7:0]                     data_o,
  output logic                           valid_o,
  input  logic                           ready_i,
  output logic                           last_o,
  output logic [CH_W-1:0]                chan_o,
  output logic                           busy_o,
  output logic [NUM_CH-1:0]              done_o
);
  logic              act_q, pend_q;
  logic [CH_W-1:0]   ch_q, pch_q, go_ch;
  logic [OFF_W-1:0]  len_q, cnt_q;
  logic              go_any, go_acc, hs, fin;
  logic [DATA_W-1:0] cur_word;

  always_comb begin
    go_ch = '0;
    for (int c = 0; c < NUM_CH; c++) if (go_i[c]) go_ch = CH_W'(c);
  end

  assign go_any  = |go_i;
  // a channel already sending or waiting ignores a new start
  assign go_acc  = go_any && en_i && !(act_q && ch_q == go_ch) && !(pend_q && pch_q == go_ch);
  assign valid_o = act_q && (len_q != '0);
  assign hs      = valid_o && ready_i;
  assign last_o  = valid_o && (cnt_q == len_q - OFF_W'(1));
  assign fin     = act_q && ((len_q == '0) || (hs && last_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0; pend_q <= 1'b0; ch_q <= '0; pch_q <= '0;
      len_q <= '0;   cnt_q <= '0;
    end else if (clr_i) begin
      act_q <= 1'b0; pend_q <= 1'b0; ch_q <= '0; pch_q <= '0;
      len_q <= '0;   cnt_q <= '0;
    end else begin
      if (fin) begin
        if (pend_q) begin
          ch_q   <= pch_q;
          len_q  <= len_i[pch_q];
          cnt_q  <= '0;
          pend_q <= 1'b0;
        end else begin
          act_q <= 1'b0;
        end
      end else if (hs) begin
        cnt_q <= cnt_q + OFF_W'(1);
      end
      if (go_acc) begin
        if (!act_q || (fin && !pend_q)) begin
          act_q <= 1'b1;
          ch_q  <= go_ch;
          len_q <= len_i[go_ch];
          cnt_q <= '0;
        end else begin
          pend_q <= 1'b1;
          pch_q  <= go_ch;
        end
      end
    end
  end

  assign rd_idx_o = cnt_q[OFF_W-2:LANE_W];
  assign cur_word = words_i[ch_q];
  assign data_o   = cur_word[{cnt_q[LANE_W-1:0], 3'b000} +: 8];
  assign chan_o   = ch_q;
  assign busy_o   = act_q;

  always_comb begin
    done_o = '0;
    if (fin) done_o[ch_q] = 1'b1;
  end
endmodule

// File: rtl/txb_irq.sv
module txb_irq
  import txb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              ien_we_i,
  input  logic              sts_we_i,
  input  logic [NUM_CH-1:0] wdata_i,
  input  logic [NUM_CH-1:0] set_i,
  output logic [NUM_CH-1:0] ien_o,
  output logic [NUM_CH-1:0] sts_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] ien_q, sts_q, clr_bits;

  assign clr_bits = sts_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q <= '0; sts_q <= '0;
    end else if (clr_i) begin
      ien_q <= '0; sts_q <= '0;
    end else begin
      if (ien_we_i) ien_q <= wdata_i;
      sts_q <= (sts_q & ~clr_bits) | set_i;  // a new event beats a clear
    end
  end

  assign ien_o = ien_q;
  assign sts_o = sts_q;
  assign irq_o = |(sts_q & ien_q);
endmodule

// File: rtl/txb_top.sv
module txb_top
  import txb_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BUF_BYTES = 2048,
  parameter int ADDR_W    = 4,
  localparam int LANES  = DATA_W / 8,
  localparam int WORDS  = BUF_BYTES / LANES,
  localparam int OFF_W  = $clog2(BUF_BYTES) + 1,
  localparam int WIDX_W = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic              tx_last_o,
  output logic [CH_W-1:0]   tx_chan_o,
  output logic              irq_o
);
  logic [DATA_W-1:0]              ctrl_q;
  logic [CH_W-1:0]                sel_q;
  logic [NUM_CH-1:0][OFF_W-1:0]   len_q;
  logic [NUM_CH-1:0][DATA_W-1:0]  words;
  logic [NUM_CH-1:0]              go, len_we, bank_we, done_w, ien, sts;
  logic [WIDX_W-1:0]              rd_idx;
  logic                           clr, ctrl_we, sel_we, data_we, ien_we, sts_we;
  logic                           tx_busy, tx_en;

  always_comb begin
    ctrl_we = wr_en_i && wr_addr_i == ADDR_W'(A_CTRL);
    sel_we  = wr_en_i && wr_addr_i == ADDR_W'(A_SEL);
    data_we = wr_en_i && wr_addr_i == ADDR_W'(A_DATA);
    ien_we  = wr_en_i && wr_addr_i == ADDR_W'(A_IEN);
    sts_we  = wr_en_i && wr_addr_i == ADDR_W'(A_ISTS);
    clr     = ctrl_we && wr_data_i[CTRL_RST_BIT];
    for (int c = 0; c < NUM_CH; c++) begin
      len_we[c]  = wr_en_i && wr_addr_i == ADDR_W'(A_LEN0 + c);
      go[c]      = wr_en_i && wr_addr_i == ADDR_W'(A_GO0 + c) && wr_data_i[0];
      bank_we[c] = data_we && sel_q == CH_W'(c);
    end
  end

  assign tx_en = ctrl_q[CTRL_EN_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      sel_q  <= '0;
    end else begin
      if (ctrl_we)  ctrl_q <= {wr_data_i[DATA_W-1:1], 1'b0};
      if (clr)      sel_q  <= '0;
      else if (sel_we) sel_q <= (wr_data_i < DATA_W'(NUM_CH)) ? wr_data_i[CH_W-1:0] : '0;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        len_q[c] <= '0;
      else if (clr)       len_q[c] <= '0;
      else if (len_we[c]) len_q[c] <= (wr_data_i > DATA_W'(BUF_BYTES)) ? OFF_W'(BUF_BYTES)
                                                                      : wr_data_i[OFF_W-1:0];
    end

    txb_bank #(.DATA_W(DATA_W), .BUF_BYTES(BUF_BYTES)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (clr),
      .wr_i     (bank_we[c]),
      .wdata_i  (wr_data_i),
      .done_i   (done_w[c]),
      .rd_idx_i (rd_idx),
      .rd_word_o(words[c])
    );
  end

  txb_sched #(.DATA_W(DATA_W), .BUF_BYTES(BUF_BYTES)) u_sched (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .en_i    (tx_en),
    .go_i    (go),
    .len_i   (len_q),
    .words_i (words),
    .rd_idx_o(rd_idx),
    .data_o  (tx_data_o),
    .valid_o (tx_valid_o),
    .ready_i (tx_ready_i),
    .last_o  (tx_last_o),
    .chan_o  (tx_chan_o),
    .busy_o  (tx_busy),
    .done_o  (done_w)
  );

  txb_irq u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .ien_we_i(ien_we),
    .sts_we_i(sts_we),
    .wdata_i (wr_data_i[NUM_CH-1:0]),
    .set_i   (done_w),
    .ien_o   (ien),
    .sts_o   (sts),
    .irq_o   (irq_o)
  );

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      ADDR_W'(A_CTRL):     rd_data_o = ctrl_q;
      ADDR_W'(A_SEL):      rd_data_o = DATA_W'(sel_q);
      ADDR_W'(A_LEN0):     rd_data_o = DATA_W'(len_q[0]);
      ADDR_W'(A_LEN0 + 1): rd_data_o = DATA_W'(len_q[1]);
      ADDR_W'(A_IEN):      rd_data_o = DATA_W'(ien);
      ADDR_W'(A_ISTS):     rd_data_o = DATA_W'(sts);
      default:             rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/txb_chk.sv
module txb_chk
  import txb_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BUF_BYTES = 2048,
  parameter int ADDR_W    = 4,
  localparam int OFF_W = $clog2(BUF_BYTES) + 1
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         wr_en_i,
  input logic [ADDR_W-1:0]            wr_addr_i,
  input logic [DATA_W-1:0]            wr_data_i,
  input logic                         tx_valid_o,
  input logic                         tx_ready_i,
  input logic                         tx_last_o,
  input logic [CH_W-1:0]              tx_chan_o,
  input logic                         irq_o,
  input logic                         tx_busy,
  input logic                         tx_en,
  input logic [NUM_CH-1:0]            done_w,
  input logic [NUM_CH-1:0][OFF_W-1:0] len_q
);
  logic go_wr, ctrl_rst_wr, ien_wr;
  assign go_wr       = wr_en_i && wr_data_i[0] &&
                       (wr_addr_i == ADDR_W'(A_GO0) || wr_addr_i == ADDR_W'(A_GO0 + 1));
  assign ctrl_rst_wr = wr_en_i && wr_addr_i == ADDR_W'(A_CTRL) && wr_data_i[CTRL_RST_BIT];
  assign ien_wr      = wr_en_i && wr_addr_i == ADDR_W'(A_IEN);

  p_hold_chan_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i && !ctrl_rst_wr |=> tx_valid_o && $stable(tx_chan_o));

  p_last_needs_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_last_o |-> tx_valid_o);

  p_len0_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_q[0] <= OFF_W'(BUF_BYTES));

  p_len1_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_q[1] <= OFF_W'(BUF_BYTES));

  p_gated_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy && go_wr && !tx_en |=> !tx_busy);

  p_irq_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|done_w || ien_wr));

  p_soft_reset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rst_wr |=> !tx_valid_o && !irq_o && !tx_busy);

  p_done_when_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |done_w |-> tx_busy && $onehot0(done_w));
endmodule

bind txb_top txb_chk #(.DATA_W(DATA_W), .BUF_BYTES(BUF_BYTES), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .tx_valid_o(tx_valid_o),
  .tx_ready_i(tx_ready_i),
  .tx_last_o (tx_last_o),
  .tx_chan_o (tx_chan_o),
  .irq_o     (irq_o),
  .tx_busy   (tx_busy),
  .tx_en     (tx_en),
  .done_w    (done_w),
  .len_q     (len_q)
);

// File: tb/txb_top_tb.sv
module txb_top_tb;
  localparam int BUF = 2048;
  localparam int NW  = BUF / 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [3:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic [7:0]  tx_data_o;
  logic        tx_valid_o, tx_ready_i, tx_last_o, irq_o;
  logic [0:0]  tx_chan_o;

  always #4 clk_i = ~clk_i;

  txb_top u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i),
    .tx_last_o(tx_last_o), .tx_chan_o(tx_chan_o), .irq_o(irq_o)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // bench model
  logic [31:0] mdl_mem [2][NW];
  int mdl_off [2];
  int mdl_len [2];
  int mdl_sel, mdl_ien, mdl_sts;
  bit mdl_en;
  bit mdl_busy [2];

  logic [7:0] exp_b [8192]; int exp_c [8192]; bit exp_l [8192]; int exp_n = 0;
  logic [7:0] cap_b [8192]; int cap_c [8192]; bit cap_l [8192]; int cap_n = 0;
  bit mon_quiet = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(int ch, int i);
    logic [31:0] w;
    w = mdl_mem[ch][i >> 2];
    return w[8 * (i % 4) +: 8];
  endfunction

  function automatic int clamp_len(logic [31:0] v);
    return (v > BUF) ? BUF : int'(v);
  endfunction

  // monitor: random ready, capture handshakes, check hold while stalled (R6)
  initial begin
    bit stall; logic [7:0] pd; logic [0:0] pc;
    stall = 0; pd = '0; pc = '0;
    tx_ready_i = 1'b0;
    forever begin
      @(negedge clk_i);
      tx_ready_i = ($urandom % 4) != 0;
      #1;
      if (stall && !mon_quiet)
        chk(tx_valid_o && tx_data_o == pd && tx_chan_o == pc, "R6 hold while stalled",
            {23'd0, tx_valid_o, tx_data_o}, {24'd1, pd});
      stall = tx_valid_o && !tx_ready_i;
      pd = tx_data_o; pc = tx_chan_o;
      if (tx_valid_o && tx_ready_i && cap_n < 8192) begin
        cap_b[cap_n] = tx_data_o; cap_c[cap_n] = int'(tx_chan_o); cap_l[cap_n] = tx_last_o;
        cap_n++;
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 4'(a); wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk_i);
    rd_addr_i = 4'(a);
    #1 d = rd_data_o;
  endtask

  task automatic host_sel(input logic [31:0] v);
    wr(1, v);
    mdl_sel = (v < 2) ? int'(v) : 0;
  endtask

  task automatic host_data(input logic [31:0] w);
    wr(2, w);
    if (mdl_off[mdl_sel] < BUF) begin
      mdl_mem[mdl_sel][mdl_off[mdl_sel] / 4] = w;
      mdl_off[mdl_sel] += 4;
    end
  endtask

  task automatic host_len(input int ch, input logic [31:0] v);
    wr(3 + ch, v);
    mdl_len[ch] = clamp_len(v);
  endtask

  task automatic host_go(input int ch);
    wr(5 + ch, 32'd1);
    if (mdl_en && !mdl_busy[ch]) begin
      mdl_busy[ch] = 1;
      for (int i = 0; i < mdl_len[ch]; i++) begin
        exp_b[exp_n] = exp_byte(ch, i); exp_c[exp_n] = ch; exp_l[exp_n] = (i == mdl_len[ch] - 1);
        exp_n++;
      end
      mdl_off[ch] = 0;
    end
  endtask

  task automatic drain(input string tag);
    int bad; logic [31:0] v;
    bad = -1;
    for (int k = 0; k < 20000 && cap_n < exp_n; k++) @(negedge clk_i);
    repeat (6) @(negedge clk_i);
    chk(cap_n == exp_n, {tag, " byte count"}, cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++)
      if (bad < 0 && (cap_b[i] != exp_b[i] || cap_c[i] != exp_c[i] || cap_l[i] != exp_l[i])) bad = i;
    if (bad >= 0)
      chk(0, {tag, " frame bytes"}, {cap_l[bad], 7'(cap_c[bad]), cap_b[bad]}, {exp_l[bad], 7'(exp_c[bad]), exp_b[bad]});
    else
      chk(1, {tag, " frame bytes"}, 0, 0);
    for (int c = 0; c < 2; c++) if (mdl_busy[c]) begin mdl_sts |= (1 << c); mdl_busy[c] = 0; end
    rd(8, v);
    chk(v == 32'(mdl_sts), {tag, " R7 status"}, v, mdl_sts);
    chk(irq_o == ((mdl_sts & mdl_ien) != 0), {tag, " R8 irq"}, irq_o, (mdl_sts & mdl_ien) != 0);
    cap_n = 0; exp_n = 0;
  endtask

  task automatic host_w1c(input int m);
    wr(8, 32'(m));
    mdl_sts &= ~m;
  endtask

  initial begin
    int seed_v; logic [31:0] v;
    seed_v = $urandom(32'd20240611);
    for (int c = 0; c < 2; c++) begin
      mdl_off[c] = 0; mdl_len[c] = 0; mdl_busy[c] = 0;
      for (int i = 0; i < NW; i++) mdl_mem[c][i] = '0;
    end
    mdl_sel = 0; mdl_ien = 0; mdl_sts = 0; mdl_en = 0;
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset values
    for (int a = 0; a < 9; a++) begin
      rd(a, v);
      chk(v == 0, $sformatf("R1 reg %0d after reset", a), v, 0);
    end
    chk(!irq_o && !tx_valid_o, "R1 outputs after reset", {irq_o, tx_valid_o}, 0);

    // R2 select clamping
    host_sel(1); rd(1, v); chk(v == 1, "R2 select 1", v, 1);
    host_sel(2); rd(1, v); chk(v == 0, "R2 select 2 -> 0", v, 0);
    host_sel(1); host_sel(32'hFFFF_FFFF); rd(1, v); chk(v == 0, "R2 select big -> 0", v, 0);

    // R4 length clamping
    host_len(0, 3000); rd(3, v); chk(v == BUF, "R4 len 3000", v, BUF);
    host_len(1, 2049); rd(4, v); chk(v == BUF, "R4 len 2049", v, BUF);
    host_len(1, 2048); rd(4, v); chk(v == BUF, "R4 len 2048", v, BUF);
    host_len(0, 100);  rd(3, v); chk(v == 100, "R4 len 100", v, 100);

    // R5 start ignored with transmit disabled
    host_go(0);
    repeat (10) @(negedge clk_i);
    chk(cap_n == 0 && !tx_valid_o, "R5 no bytes while disabled", cap_n, 0);
    rd(8, v); chk(v == 0, "R5 no status while disabled", v, 0);

    wr(0, 32'h2); mdl_en = 1;
    rd(0, v); chk(v == 2, "R9 control readback", v, 2);

    // R3 fill past end of each buffer, R6 full-length send
    for (int c = 0; c < 2; c++) begin
      host_sel(c);
      for (int i = 0; i < NW + 8; i++) host_data($urandom);
      host_len(c, BUF);
      host_go(c);
      drain($sformatf("R3 R6 full buffer ch%0d", c));
      host_w1c(3);
    end

    // R7 offset back to 0 after completion
    host_sel(0);
    host_data(32'h4433_2211); host_data(32'h8877_6655); host_data(32'hCCBB_AA99);
    host_len(0, 10);
    host_go(0);
    drain("R7 rewrite from word 0");
    chk(mdl_mem[0][0] == 32'h4433_2211, "R6 model lsb-first seed", mdl_mem[0][0], 32'h4433_2211);

    // R8 interrupt masking and write-one-to-clear
    chk(!irq_o, "R8 irq masked", irq_o, 0);
    wr(7, 32'h1); mdl_ien = 1;
    @(negedge clk_i); chk(irq_o, "R8 irq enabled", irq_o, 1);
    host_w1c(2);
    @(negedge clk_i); chk(irq_o, "R8 clear other bit keeps irq", irq_o, 1);
    rd(8, v); chk(v == 1, "R8 status kept", v, 1);
    host_w1c(1);
    @(negedge clk_i); chk(!irq_o, "R8 cleared", irq_o, 0);

    // R11 zero-length send
    host_len(1, 0);
    host_go(1);
    drain("R11 zero length");
    host_w1c(3);

    // R10 repeat starts ignored, other channel queued in order
    host_sel(0);
    for (int i = 0; i < 10; i++) host_data($urandom);
    host_len(0, 40);
    host_sel(1);
    for (int i = 0; i < 5; i++) host_data($urandom);
    host_len(1, 19);
    host_go(0); host_go(0); host_go(1); host_go(1);
    drain("R10 queued order");
    chk(mdl_sts == 3, "R10 both complete", mdl_sts, 3);
    host_w1c(3);

    // random mix
    for (int it = 0; it < 24; it++) begin
      int ch; int lenv; int nw; logic [31:0] sv;
      ch = $urandom % 2;
      sv = (ch == 1) ? 32'd1 : ((($urandom % 3) == 0) ? 32'(2 + $urandom % 100) : 32'd0);
      host_sel(sv);
      rd(1, v); chk(v == 32'(ch), "R2 random select", v, ch);
      lenv = ((it % 8) == 7) ? 2049 + int'($urandom % 2000) : int'($urandom % 600);
      nw = int'($urandom % (lenv / 4 + 3));
      if (nw > NW + 4) nw = NW + 4;
      for (int i = 0; i < nw; i++) host_data($urandom);
      host_len(ch, 32'(lenv));
      rd(3 + ch, v); chk(v == 32'(clamp_len(32'(lenv))), "R4 random length", v, clamp_len(32'(lenv)));
      host_go(ch);
      drain($sformatf("R6 random it%0d", it));
      host_w1c(3);
    end

    // R9 soft reset in mid-frame
    wr(7, 32'h3); mdl_ien = 3;
    host_sel(1); host_len(1, BUF); host_go(1);
    repeat (50) @(negedge clk_i);
    mon_quiet = 1;
    wr(0, 32'h3);
    repeat (3) @(negedge clk_i);
    chk(!tx_valid_o && !irq_o, "R9 stream stopped", {tx_valid_o, irq_o}, 0);
    rd(0, v); chk(v == 2, "R9 reset bit not kept", v, 2);
    rd(1, v); chk(v == 0, "R9 select cleared", v, 0);
    rd(4, v); chk(v == 0, "R9 length cleared", v, 0);
    rd(7, v); chk(v == 0, "R9 enable cleared", v, 0);
    rd(8, v); chk(v == 0, "R9 status cleared", v, 0);
    cap_n = 0; exp_n = 0;
    mdl_sel = 0; mdl_ien = 0; mdl_sts = 0; mdl_busy[0] = 0; mdl_busy[1] = 0;
    mdl_off[0] = 0; mdl_off[1] = 0; mdl_len[0] = 0; mdl_len[1] = 0;
    mon_quiet = 0;
    // offsets restart at 0 after soft reset
    host_sel(1); host_data(32'hDEAD_BEEF); host_len(1, 4); host_go(1);
    drain("R9 offset cleared");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule